// File: doc/BRIEF.md
# Output Compare Channel Bank with Forced Compare

A bank of output compare channels that watches an external free-running 16-bit timer count. Each channel holds a 16-bit compare value. When the count reaches that value on a timer tick, the channel applies a selectable action to its output pin and raises a status flag. The count and the tick-enable come from outside the block.

Software reaches the compare values through a byte-wide register port. Each value is split into a high byte and a low byte. A write to the high byte holds off that channel's compare for the next cycle, so a value that is only half written cannot cause a false match. A force register makes chosen channels apply their pin action at the next timer tick without a match. A forced action never raises a flag. A flag register reports the flags, and writing ones to it clears them.

The pin action of each channel is chosen by a 2-bit select input. The prescaler, the counter and interrupt routing are outside this block. A channel whose compare is not wanted can use its compare register as two bytes of plain storage.

Top module: `occ_bank`

## Requirements
- R1: After reset every compare register reads 0xFFFF, every pin is low, every flag is clear and the force register reads 0x00.
- R2: Channel i (counting from 0) has its high compare byte at address 2*i and its low byte at address 2*i+1. Both bytes read back what was last written, with no effect on pins or flags.
- R3: On a cycle with tick_en high and cnt_val equal to a channel's compare value, the channel sets its flag and, on the next clock edge, updates its pin by its 2-bit action code: 00 hold, 01 toggle, 10 drive low, 11 drive high. No pin or flag changes when the count differs from the compare value.
- R4: With tick_en low, no pin and no flag changes, even when cnt_val equals a compare value.
- R5: In the cycle right after a write to a channel's high compare byte, that channel does not match. A write to the low byte holds nothing off.
- R6: The force register sits at address 2*NUM_CH, with channel i at bit 7-i. Writing a 1 there makes channel i apply its pin action at the first tick_en cycle after the write cycle, and never sets a flag. A tick in the write cycle itself does not serve the force. The pending force is dropped after one tick, and the register always reads 0x00.
- R7: When a pending force and a match fall on the same tick, the pin action is applied once and the flag is set.
- R8: The flag register sits at address 2*NUM_CH+1, with channel i at bit 7-i. Writing 1 to a bit clears that flag and writing 0 leaves it alone. When a match and a clear fall in the same cycle, the flag stays set.
- R9: bus_rdata is registered and shows, one cycle later, the byte at the address presented. Addresses above 2*NUM_CH+1 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | ADDR_W (4) | Byte address |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Registered read data |
| tick_en | input | 1 | Timer count transition this cycle |
| cnt_val | input | CNT_W (16) | Free-running counter value |
| pin_act | input | 2*NUM_CH (10) | Per-channel 2-bit pin action code |
| pin_out | output | NUM_CH (5) | Compare output pins |
| flag_out | output | NUM_CH (5) | Compare status flags |

## Verification
The hardest case to reach is the inhibited cycle. A high-byte write must be followed at once by a tick whose count equals the new mixed value: the new high byte with the old low byte. The bench drives exactly that count in the next cycle and expects no flag. It repeats the same count one cycle later and expects a match, which shows the hold-off lasts one cycle. A low-byte write followed by a matching tick shows that low-byte writes hold nothing off. The force cases also need exact cycle placement: a force written in a tick cycle, and a force that lands on a true match.

// File: rtl/occ_pkg.sv
package occ_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;

  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    logic nxt;
    case (pin_act_e'(code))
      ACT_TOGGLE: nxt = ~cur;
      ACT_LOW:    nxt = 1'b0;
      ACT_HIGH:   nxt = 1'b1;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/occ_channel.sv
module occ_channel #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [1:0]        act,
  input  logic              force_fire,
  input  logic              clr_flag,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              pin_q,
  output logic              flag_q
);
  import occ_pkg::*;

  logic inhibit_q;
  logic match;
  logic fire;

  // compare holds off for one cycle after a high-byte write
  assign match = tick && !inhibit_q && (cnt == cmp_q);
  assign fire  = match || force_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q     <= '1;
      inhibit_q <= 1'b0;
    end else begin
      inhibit_q <= wr_hi;
      if (wr_hi) cmp_q[CNT_W-1:DATA_W] <= wdata;
      if (wr_lo) cmp_q[DATA_W-1:0]     <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
    end else if (fire) begin
      pin_q <= apply_act(act, pin_q);
    end
  end

  // a match wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (match) begin
      flag_q <= 1'b1;
    end else if (clr_flag) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/occ_force.sv
module occ_force #(
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_req,
  input  logic              tick,
  output logic [NUM_CH-1:0] fire
);
  logic [NUM_CH-1:0] pend_q;

  assign fire = tick ? pend_q : '0;

  // new requests survive a tick in their own write cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      pend_q <= (tick ? '0 : pend_q) | set_req;
    end
  end

endmodule

// File: rtl/occ_bus.sv
module occ_bus #(
  parameter int NUM_CH = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_all,
  input  logic [NUM_CH-1:0]            flags,
  output logic [NUM_CH-1:0]            wr_hi,
  output logic [NUM_CH-1:0]            wr_lo,
  output logic [NUM_CH-1:0]            force_set,
  output logic [NUM_CH-1:0]            flag_clr,
  output logic [DATA_W-1:0]            rdata
);
  localparam logic [ADDR_W-1:0] FORCE_ADDR = ADDR_W'(2 * NUM_CH);
  localparam logic [ADDR_W-1:0] FLAG_ADDR  = ADDR_W'(2 * NUM_CH + 1);

  logic [DATA_W-1:0] rd_next;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign wr_hi[i]     = we && (addr == ADDR_W'(2 * i));
    assign wr_lo[i]     = we && (addr == ADDR_W'(2 * i + 1));
    assign force_set[i] = we && (addr == FORCE_ADDR) && wdata[DATA_W-1-i];
    assign flag_clr[i]  = we && (addr == FLAG_ADDR) && wdata[DATA_W-1-i];
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(2 * i))     rd_next = cmp_all[i][CNT_W-1:DATA_W];
      if (addr == ADDR_W'(2 * i + 1)) rd_next = cmp_all[i][DATA_W-1:0];
      if (addr == FLAG_ADDR)          rd_next[DATA_W-1-i] = flags[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/occ_bank.sv
module occ_bank #(
  parameter int NUM_CH = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(2 * NUM_CH + 2),
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  tick_en,
  input  logic [CNT_W-1:0]      cnt_val,
  input  logic [2*NUM_CH-1:0]   pin_act,
  output logic [NUM_CH-1:0]     pin_out,
  output logic [NUM_CH-1:0]     flag_out
);
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_all;
  logic [NUM_CH-1:0]            wr_hi, wr_lo, force_set, flag_clr, force_fire;

  occ_bus #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .cmp_all(cmp_all), .flags(flag_out), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .force_set(force_set), .flag_clr(flag_clr), .rdata(bus_rdata)
  );

  occ_force #(.NUM_CH(NUM_CH)) u_force (
    .clk(clk), .rst(rst), .set_req(force_set), .tick(tick_en), .fire(force_fire)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    occ_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst(rst), .wr_hi(wr_hi[i]), .wr_lo(wr_lo[i]),
      .wdata(bus_wdata), .tick(tick_en), .cnt(cnt_val),
      .act(pin_act[2*i +: 2]), .force_fire(force_fire[i]),
      .clr_flag(flag_clr[i]), .cmp_q(cmp_all[i]),
      .pin_q(pin_out[i]), .flag_q(flag_out[i])
    );
  end

endmodule

// File: rtl/occ_bank_chk.sv
module occ_bank_chk #(
  parameter int NUM_CH = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         bus_we,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic [DATA_W-1:0]            bus_rdata,
  input logic                         tick_en,
  input logic [CNT_W-1:0]             cnt_val,
  input logic [2*NUM_CH-1:0]          pin_act,
  input logic [NUM_CH-1:0]            pin_out,
  input logic [NUM_CH-1:0]            flag_out,
  input logic [NUM_CH-1:0][CNT_W-1:0] cmp_vals
);
  localparam logic [ADDR_W-1:0] FORCE_ADDR = ADDR_W'(2 * NUM_CH);
  localparam logic [ADDR_W-1:0] FLAG_ADDR  = ADDR_W'(2 * NUM_CH + 1);

  AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr) == FORCE_ADDR |-> bus_rdata == '0); // R6

  AST_PINS_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(pin_out)); // R4

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_FLAG_FROM_MATCH: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_out[i]) |-> $past(tick_en && (cnt_val == cmp_vals[i]))); // R3

    AST_HOLD_ACTION_STEADY: assert property (@(posedge clk) disable iff (rst)
      tick_en && (pin_act[2*i +: 2] == 2'b00) |=> $stable(pin_out[i])); // R3

    AST_HIGH_WRITE_INHIBIT: assert property (@(posedge clk) disable iff (rst)
      $past(bus_we && (bus_addr == ADDR_W'(2 * i))) && !flag_out[i] |=> !flag_out[i]); // R5

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
      bus_we && (bus_addr == FLAG_ADDR) && bus_wdata[DATA_W-1-i] && !tick_en
      |=> !flag_out[i]); // R8
  end

endmodule

bind occ_bank occ_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
  .cnt_val(cnt_val), .pin_act(pin_act), .pin_out(pin_out),
  .flag_out(flag_out), .cmp_vals(cmp_all)
);

// File: tb/tb_occ_bank.sv
module tb_occ_bank;
  localparam int NCH = 5;
  localparam logic [3:0] A_FORCE = 4'd10;
  localparam logic [3:0] A_FLAG  = 4'd11;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        tick_en;
  logic [15:0] cnt_val;
  logic [9:0]  pin_act;
  logic [4:0]  pin_out;
  logic [4:0]  flag_out;

  int checks = 0;
  int fails  = 0;
  logic [4:0]  exp_pin;
  logic [4:0]  exp_flag;
  logic [15:0] cv [NCH];
  logic [7:0]  rv;

  always #2 clk = ~clk;

  occ_bank dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .cnt_val(cnt_val), .pin_act(pin_act), .pin_out(pin_out), .flag_out(flag_out)
  );

  function automatic logic ap(input logic [1:0] a, input logic p);
    case (a)
      2'b01:   return ~p;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return p;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " pins"}, 32'(pin_out), 32'(exp_pin));
    chk({req, " flags"}, 32'(flag_out), 32'(exp_flag));
  endtask

  // one full cycle: drive after a falling edge, return at the next one
  task automatic cyc(input logic we, input logic [3:0] a, input logic [7:0] d,
                     input logic tk, input logic [15:0] c);
    bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk; cnt_val = c;
    @(negedge clk);
    bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 16'h0000);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    cyc(1'b0, a, 8'h00, 1'b0, 16'h0000);
    v = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    tick_en = 1'b0; cnt_val = '0; pin_act = '0;
    exp_pin = '0; exp_flag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_state("R1 reset");
    for (int a = 0; a < 2 * NCH; a++) begin
      rd(4'(a), rv);
      chk("R1 reset compare byte", 32'(rv), 32'hFF);
    end
    rd(A_FORCE, rv); chk("R1 force reset", 32'(rv), 32'h00);
    rd(A_FLAG, rv);  chk("R1 flag reset", 32'(rv), 32'h00);

    // R2 storage and readback of every compare byte
    for (int a = 0; a < 2 * NCH; a++) wr(4'(a), 8'(8'h5A ^ (a * 8'h13)));
    for (int a = 0; a < 2 * NCH; a++) begin
      rd(4'(a), rv);
      chk("R2 byte readback", 32'(rv), 32'(8'(8'h5A ^ (a * 8'h13))));
    end
    chk_state("R2 no side effect");

    // R3 / R4 sweep over channels and action codes
    for (int ch = 0; ch < NCH; ch++) begin
      for (int act = 0; act < 4; act++) begin
        logic [15:0] v;
        v = {4'(ch + 1), 4'(act), 8'(8'h35 + ch * 4 + act)};
        wr(4'(2 * ch), v[15:8]);
        wr(4'(2 * ch + 1), v[7:0]);
        cv[ch] = v;
        pin_act = '0;
        pin_act[2*ch +: 2] = 2'(act);
        cyc(1'b0, 4'd0, 8'd0, 1'b1, v - 16'd1);
        chk_state("R3 near miss");
        cyc(1'b0, 4'd0, 8'd0, 1'b0, v);
        chk_state("R4 equal without tick");
        cyc(1'b0, 4'd0, 8'd0, 1'b1, v);
        exp_pin[ch] = ap(2'(act), exp_pin[ch]); exp_flag[ch] = 1'b1;
        chk_state("R3 match");
        cyc(1'b0, 4'd0, 8'd0, 1'b1, v);
        exp_pin[ch] = ap(2'(act), exp_pin[ch]);
        chk_state("R3 second match");
        wr(A_FLAG, 8'h80 >> ch);
        exp_flag[ch] = 1'b0;
        chk_state("R8 clear after match");
      end
    end

    // R5 high-byte write inhibit on channel 1
    pin_act = 10'b00_00_00_01_00;
    wr(4'd2, 8'hA1);
    cv[1][15:8] = 8'hA1;
    cyc(1'b0, 4'd0, 8'd0, 1'b1, cv[1]);
    chk_state("R5 inhibited cycle");
    cyc(1'b0, 4'd0, 8'd0, 1'b1, cv[1]);
    exp_pin[1] = ~exp_pin[1]; exp_flag[1] = 1'b1;
    chk_state("R5 match after inhibit");
    wr(A_FLAG, 8'h40); exp_flag[1] = 1'b0;
    wr(4'd3, 8'h22);
    cv[1][7:0] = 8'h22;
    cyc(1'b0, 4'd0, 8'd0, 1'b1, cv[1]);
    exp_pin[1] = ~exp_pin[1]; exp_flag[1] = 1'b1;
    chk_state("R5 low byte no inhibit");
    wr(A_FLAG, 8'h40); exp_flag[1] = 1'b0;
    chk_state("R8 clear ch1");

    // R6 forced compare on channel 2 (drive low)
    pin_act = 10'b00_00_10_00_00;
    wr(A_FORCE, 8'h20);
    chk_state("R6 no action at write");
    cyc(1'b0, 4'd0, 8'd0, 1'b0, 16'h0100);
    chk_state("R6 pending without tick");
    rd(A_FORCE, rv); chk("R6 force reads zero", 32'(rv), 32'h00);
    cyc(1'b0, 4'd0, 8'd0, 1'b1, 16'h0100);
    exp_pin[2] = 1'b0;
    chk_state("R6 forced action no flag");
    pin_act = 10'b00_00_11_00_00;
    cyc(1'b0, 4'd0, 8'd0, 1'b1, 16'h0100);
    chk_state("R6 force dropped after tick");

    // R6 all channels forced with mixed actions
    pin_act = 10'b00_11_01_10_01;
    wr(A_FORCE, 8'hF8);
    cyc(1'b0, 4'd0, 8'd0, 1'b1, 16'h0100);
    for (int ch = 0; ch < NCH; ch++) exp_pin[ch] = ap(pin_act[2*ch +: 2], exp_pin[ch]);
    chk_state("R6 all channels forced");

    // R6 force written during a tick waits for the next tick
    pin_act = 10'b01_00_00_00_00;
    cyc(1'b1, A_FORCE, 8'h08, 1'b1, 16'h0100);
    chk_state("R6 write-cycle tick ignored");
    cyc(1'b0, 4'd0, 8'd0, 1'b1, 16'h0100);
    exp_pin[4] = ~exp_pin[4];
    chk_state("R6 served on next tick");

    // R7 force and match on the same tick, toggle on channel 3
    pin_act = 10'b00_01_00_00_00;
    wr(A_FORCE, 8'h10);
    cyc(1'b0, 4'd0, 8'd0, 1'b1, cv[3]);
    exp_pin[3] = ~exp_pin[3]; exp_flag[3] = 1'b1;
    chk_state("R7 single action with flag");

    // R8 flag register behaviour
    wr(A_FLAG, 8'h00);
    chk_state("R8 zero write keeps flag");
    rd(A_FLAG, rv); chk("R9 flag readback", 32'(rv), 32'h10);
    cyc(1'b1, A_FLAG, 8'h10, 1'b1, cv[3]);
    exp_pin[3] = ~exp_pin[3];
    chk_state("R8 set wins over clear");
    wr(A_FLAG, 8'h10); exp_flag[3] = 1'b0;
    chk_state("R8 clear");

    // R9 unmapped reads and final compare readback
    for (int a = 12; a < 16; a++) begin
      rd(4'(a), rv);
      chk("R9 unmapped read", 32'(rv), 32'h00);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      rd(4'(2 * ch), rv);     chk("R2 final high byte", 32'(rv), 32'(cv[ch][15:8]));
      rd(4'(2 * ch + 1), rv); chk("R2 final low byte", 32'(rv), 32'(cv[ch][7:0]));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule